// File: doc/BRIEF.md
# Regulator Output Power-Good and Fault Supervisor

This block is the digital supervisor for one channel of a switching regulator. Comparators outside the block report four conditions as single-bit flags: the output is above the power-good window, below it, over the overvoltage limit, or under the undervoltage limit. A current-limit flag, a soft-start-done flag and an enable input come in as well. All of them are synchronous to the system clock. The block drives four outputs. The first is a power-good line in open-drain form, where a high level turns the pull-down on. The others are a channel enable, a gate-drive inhibit sent to the PWM stage, and a chip-wide fault latch.

The block treats faults in two ways. An overvoltage only blocks switching while its flag is high, and the channel recovers by itself. An undervoltage after soft-start, or a current limit that lasts too long, sets a latch that shuts the channel down. Only a power-on reset or a low level on the enable input clears that latch. Power-good waits for soft-start to finish. The window flags are synchronized and then filtered, so a short glitch cannot toggle the power-good line.

Top module: `pgsup_top`

## Requirements
- R1: While `ss_done` is 0, `pg_pull_low` is 1. When `ss_done` rises with the output inside the window and no fault present, `pg_pull_low` falls after the next clock edge.
- R2: The output counts as in-window only when `win_above` and `win_below` are both 0. A change in the window state must persist for PG_FILT_CYCLES (4) clocks after a 2-flop synchronizer before power-good follows it. If the change is applied before edge k, `pg_pull_low` follows it after edge k+6. A disturbance of 1 to 3 clocks has no effect at all, and a disturbance of w ≥ 4 clocks holds `pg_pull_low` high for exactly w cycles.
- R3: A 1 on `ov_flag` that is sampled at a clock edge sets `gate_inhibit` to 1 after that edge. An overvoltage lasting L clocks gives exactly L cycles of inhibit.
- R4: Overvoltage never sets `fault_latched`. Once `ov_flag` returns to 0 while enabled, `gate_inhibit` falls after the next edge, and power-good is not disturbed.
- R5: A 1 on `uv_flag` sampled with `enable`=1 and `ss_done`=1 sets `fault_latched` after that edge. `uv_flag` has no effect while `ss_done` is 0.
- R6: If `ilim_flag` is 1 for OL_CYCLES (8) consecutive sampled edges with `enable`=1, `fault_latched` is set after the 8th edge. A run of 7 or fewer does not set it.
- R7: Once set, `fault_latched` stays at 1 while `enable` stays at 1. It clears after the first edge that samples `enable`=0, or on reset.
- R8: While `fault_latched` is 1, or after any edge that samples `enable`=0, `pg_pull_low` is 1, `chan_en` is 0 and `gate_inhibit` is 1.
- R9: During reset the outputs are `pg_pull_low`=1, `chan_en`=0, `gate_inhibit`=1 and `fault_latched`=0.
- R10: With no latched fault, `chan_en` follows `enable` one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset, asynchronous |
| enable | input | 1 | Channel enable request; a low level clears the fault latch |
| ss_done | input | 1 | Soft-start ramp finished |
| win_above | input | 1 | Output above the upper power-good threshold |
| win_below | input | 1 | Output below the lower power-good threshold |
| ov_flag | input | 1 | Overvoltage comparator |
| uv_flag | input | 1 | Undervoltage comparator |
| ilim_flag | input | 1 | Current-limit comparator |
| pg_pull_low | output | 1 | 1 turns the open-drain power-good pull-down on (not good) |
| chan_en | output | 1 | Channel running |
| gate_inhibit | output | 1 | Blocks high-side gate drive in the PWM stage |
| fault_latched | output | 1 | Chip-wide latched shutdown |

## Verification
Some rules are checked by assertions on every cycle:
- A latched fault or a low enable forces power-good off, the channel off and the inhibit on.
- Overvoltage forces the inhibit on in the next cycle.
- An undervoltage after soft-start sets the latch.
- The latch holds while enable stays high, and a low enable clears it.
- The filter output stays put while its input agrees with it.

Other behaviour needs the bench's scenarios:
- The exact glitch-width threshold and the low duration for window disturbances of 1 to 6 clocks.
- The boundary between 7 and 8 consecutive current-limit samples.
- The exact six-edge latency of the power-good path.
- Recovery after a latched fault is cleared by enable or by reset.

// File: rtl/pgsup_pkg.sv
package pgsup_pkg;

   // Comparator fault flags grouped for the fault controller.
   typedef struct packed {
      logic ov;
      logic uv;
      logic ilim;
   } pgsup_flags_t;

   // Counter width able to hold values 0..n.
   function automatic int unsigned cnt_width(input int unsigned n);
      int unsigned w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

endpackage

// File: rtl/pgsup_sync.sv
module pgsup_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   if (STAGES < 1) begin : g_bad_stages
      $error("pgsup_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r_q <= RST_VAL;
         else        r_q <= d;
      end
      assign q = r_q;
   end else begin : g_chain
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{RST_VAL}};
         else        chain_q <= {chain_q[STAGES-2:0], d};
      end
      assign q = chain_q[STAGES-1];
   end

endmodule

// File: rtl/pgsup_filter.sv
module pgsup_filter #(
   parameter int unsigned CYCLES  = 4,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   import pgsup_pkg::*;

   localparam int unsigned CW = cnt_width(CYCLES);

   if (CYCLES < 1) begin : g_bad_cycles
      $error("pgsup_filter: CYCLES must be at least 1");
   end

   logic q_r;
   assign q = q_r;

   if (CYCLES == 1) begin : g_direct
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q_r <= RST_VAL;
         else        q_r <= d;
      end
   end else begin : g_counted
      logic [CW-1:0] run_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_r   <= RST_VAL;
            run_q <= '0;
         end else if (d == q_r) begin
            run_q <= '0;
         end else if (run_q == CW'(CYCLES - 1)) begin
            q_r   <= d;
            run_q <= '0;
         end else begin
            run_q <= run_q + 1'b1;
         end
      end
   end

   // R2: an input that agrees with the filtered value never moves it
   p_filt_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (d == q_r) |=> $stable(q_r));

endmodule

// File: rtl/pgsup_fault.sv
module pgsup_fault #(
   parameter int unsigned OL_CYCLES = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    en,
   input  logic                    ss_done,
   input  pgsup_pkg::pgsup_flags_t flags,
   output logic                    latch_q,
   output logic                    latch_nxt,
   output logic                    inhibit_q,
   output logic                    chan_en_q
);
   import pgsup_pkg::*;

   localparam int unsigned OW = cnt_width(OL_CYCLES);

   if (OL_CYCLES < 1) begin : g_bad_ol
      $error("pgsup_fault: OL_CYCLES must be at least 1");
   end

   logic [OW-1:0] ol_run_q;
   logic          ol_set;
   logic          uv_set;

   assign ol_set    = en && flags.ilim && (ol_run_q == OW'(OL_CYCLES - 1));
   assign uv_set    = en && ss_done && flags.uv;
   assign latch_nxt = en && (latch_q || uv_set || ol_set);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ol_run_q <= '0;
      end else if (!en || !flags.ilim) begin
         ol_run_q <= '0;
      end else if (ol_run_q != OW'(OL_CYCLES - 1)) begin
         ol_run_q <= ol_run_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latch_q   <= 1'b0;
         inhibit_q <= 1'b1;
         chan_en_q <= 1'b0;
      end else begin
         latch_q   <= latch_nxt;
         inhibit_q <= flags.ov || !en || latch_nxt;
         chan_en_q <= en && !latch_nxt;
      end
   end

   // R3: overvoltage blocks switching in the next cycle
   p_ov_inhibit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      flags.ov |=> inhibit_q);

   // R4: without overvoltage and with enable, inhibit only reflects the latch
   p_ov_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags.ov && en) |=> (inhibit_q == latch_q));

   // R5: undervoltage after soft-start latches the chip
   p_uv_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (en && ss_done && flags.uv) |=> latch_q);

   // R7: the latch holds while enabled and a low enable clears it
   p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (latch_q && en) |=> latch_q);
   p_latch_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !latch_q);

   // R8: a latched chip is not running and is inhibited
   p_latch_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      latch_q |-> (!chan_en_q && inhibit_q));

endmodule

// File: rtl/pgsup_top.sv
module pgsup_top #(
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned PG_FILT_CYCLES = 4,
   parameter int unsigned OL_CYCLES      = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable,
   input  logic ss_done,
   input  logic win_above,
   input  logic win_below,
   input  logic ov_flag,
   input  logic uv_flag,
   input  logic ilim_flag,
   output logic pg_pull_low,
   output logic chan_en,
   output logic gate_inhibit,
   output logic fault_latched
);
   import pgsup_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pgsup_top: SYNC_STAGES must be at least 2");
   end

   logic above_s;
   logic below_s;
   logic win_ok_s;
   logic win_ok_f;
   logic latch_nxt;
   logic pg_good_q;
   pgsup_flags_t flags;

   pgsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_above (
      .clk(clk), .rst_n(rst_n), .d(win_above), .q(above_s));

   pgsup_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_below (
      .clk(clk), .rst_n(rst_n), .d(win_below), .q(below_s));

   assign win_ok_s = !(above_s || below_s);

   pgsup_filter #(.CYCLES(PG_FILT_CYCLES), .RST_VAL(1'b0)) u_win_filt (
      .clk(clk), .rst_n(rst_n), .d(win_ok_s), .q(win_ok_f));

   assign flags = '{ov: ov_flag, uv: uv_flag, ilim: ilim_flag};

   pgsup_fault #(.OL_CYCLES(OL_CYCLES)) u_fault (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (enable),
      .ss_done   (ss_done),
      .flags     (flags),
      .latch_q   (fault_latched),
      .latch_nxt (latch_nxt),
      .inhibit_q (gate_inhibit),
      .chan_en_q (chan_en));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pg_good_q <= 1'b0;
      else        pg_good_q <= win_ok_f && enable && ss_done && !latch_nxt;
   end

   assign pg_pull_low = !pg_good_q;

   // R1: soft-start in progress keeps power-good off
   p_pg_softstart_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !ss_done |=> pg_pull_low);

   // R8: a latched fault or a disabled channel keeps power-good off
   p_pg_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fault_latched |-> pg_pull_low);
   p_pg_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (pg_pull_low && !chan_en && gate_inhibit));

   // R2: a filtered window loss pulls power-good low in the next cycle
   p_pg_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !win_ok_f |=> pg_pull_low);

endmodule

// File: tb/pgsup_top_tb.sv
`timescale 1ns/1ps
module pgsup_top_tb;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic ss_done = 1'b0;
   logic win_above = 1'b0;
   logic win_below = 1'b1;
   logic ov_flag = 1'b0;
   logic uv_flag = 1'b0;
   logic ilim_flag = 1'b0;
   logic pg_pull_low;
   logic chan_en;
   logic gate_inhibit;
   logic fault_latched;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pgsup_top u_dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .ss_done(ss_done),
      .win_above(win_above), .win_below(win_below), .ov_flag(ov_flag),
      .uv_flag(uv_flag), .ilim_flag(ilim_flag), .pg_pull_low(pg_pull_low),
      .chan_en(chan_en), .gate_inhibit(gate_inhibit),
      .fault_latched(fault_latched));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   // One clock: returns at the falling edge after the next rising edge.
   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      for (int c = 0; c < 100000; c++) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got 1 expected 0");
         summary();
         $finish;
      end
   end

   initial begin
      int lows;
      tick(3);
      // R9 reset state
      chk("R9 pg", pg_pull_low, 1);
      chk("R9 chan_en", chan_en, 0);
      chk("R9 inhibit", gate_inhibit, 1);
      chk("R9 latch", fault_latched, 0);
      rst_n = 1'b1;
      win_below = 1'b0;
      enable = 1'b1;
      tick(1);
      // R10 chan_en one edge after enable
      chk("R10 chan_en", chan_en, 1);
      tick(12);
      // R1 soft-start not done
      chk("R1 pg held", pg_pull_low, 1);
      ss_done = 1'b1;
      tick(1);
      chk("R1 pg after ss", pg_pull_low, 0);

      // R2 latency: window loss applied before edge k; low only after edge k+6
      win_above = 1'b1;
      tick(6);
      chk("R2 before latency", pg_pull_low, 0);
      tick(1);
      chk("R2 at latency", pg_pull_low, 1);
      win_above = 1'b0;
      tick(6);
      chk("R2 recover before", pg_pull_low, 1);
      tick(1);
      chk("R2 recover at", pg_pull_low, 0);

      // R2 glitch-width sweep on both window flags
      for (int f = 0; f < 2; f++) begin
         for (int w = 1; w <= 6; w++) begin
            lows = 0;
            if (f == 0) win_above = 1'b1; else win_below = 1'b1;
            for (int c = 0; c < 16; c++) begin
               if (c == w) begin
                  win_above = 1'b0;
                  win_below = 1'b0;
               end
               tick(1);
               if (pg_pull_low) lows++;
            end
            chk($sformatf("R2 glitch flag%0d w%0d", f, w), lows, (w >= 4) ? w : 0);
            tick(4);
         end
      end

      // R3 / R4 overvoltage length sweep
      for (int l = 1; l <= 5; l++) begin
         int inh;
         inh = 0;
         ov_flag = 1'b1;
         for (int c = 0; c < 10; c++) begin
            if (c == l) ov_flag = 1'b0;
            tick(1);
            if (gate_inhibit) inh++;
         end
         chk($sformatf("R3 inhibit len %0d", l), inh, l);
         chk("R4 no latch", fault_latched, 0);
         chk("R4 pg kept", pg_pull_low, 0);
      end

      // R6 overload run sweep, with R7/R8 clearing via enable
      for (int n = 1; n <= 10; n++) begin
         ilim_flag = 1'b1;
         tick(n);
         ilim_flag = 1'b0;
         chk($sformatf("R6 run %0d", n), fault_latched, (n >= 8) ? 1 : 0);
         tick(3);
         if (n >= 8) begin
            chk("R7 hold", fault_latched, 1);
            chk("R8 pg", pg_pull_low, 1);
            chk("R8 chan_en", chan_en, 0);
            chk("R8 inhibit", gate_inhibit, 1);
            enable = 1'b0;
            tick(1);
            chk("R7 clear by enable", fault_latched, 0);
            enable = 1'b1;
            tick(1);
            chk("R10 chan_en back", chan_en, 1);
            chk("R1 pg back", pg_pull_low, 0);
         end else begin
            chk("R6 pg kept", pg_pull_low, 0);
         end
      end

      // R5 undervoltage ignored during soft-start
      ss_done = 1'b0;
      uv_flag = 1'b1;
      tick(1);
      uv_flag = 1'b0;
      tick(2);
      chk("R5 uv ignored", fault_latched, 0);
      chk("R10 chan_en kept", chan_en, 1);
      ss_done = 1'b1;
      tick(1);
      uv_flag = 1'b1;
      tick(1);
      uv_flag = 1'b0;
      chk("R5 uv latch", fault_latched, 1);
      chk("R8 pg uv", pg_pull_low, 1);
      tick(5);
      chk("R7 uv hold", fault_latched, 1);
      rst_n = 1'b0;
      tick(1);
      chk("R7 clear by reset", fault_latched, 0);
      chk("R9 pg reset", pg_pull_low, 1);
      rst_n = 1'b1;
      tick(8);
      chk("R1 pg after reset", pg_pull_low, 0);

      done = 1'b1;
      summary();
      $finish;
   end

endmodule